// File: doc/BRIEF.md
# Memory-Backed FIFO Pointer Controller

This block turns a region of external word-addressed memory into a large first-in first-out buffer. Words arrive on a valid/ready input stream and are gathered in a small staging buffer. They are written to memory in bursts. Words held in memory are fetched back in bursts into a small output buffer, and a valid/ready output stream drains that buffer in arrival order. The region is set by a base address and an address mask. Every memory address is `base | (pointer & ~mask)`, so both pointers wrap inside the region.

Software sets the block up through four configuration words and reads one 32-bit readback word. A 3-bit select chooses which value the readback word shows. A clear state resets the pointers and discards all held words. Two further options are available. Reads from memory can be held back until enough words are stored. A partly filled staging buffer is flushed once it has waited longer than a programmable timeout.

Top module: `membuf_ctrl`

## Requirements
- R1: Reset behaviour. After reset the readback select is 0 and the readback word reads 0x80000000 (presence bit set, not busy, occupancy 0). Clear is held, so `in_ready` and `out_valid` are both 0.
- R2: Control word at configuration offset 0. Bit 0 is clear, bit 1 is read-hold enable, bits 15:4 are the flush timeout and bits 31:16 are the read-hold threshold. After reset clear is 1 and the timeout is 256. Offset 1 holds the 30-bit base and offset 2 holds the 30-bit mask. For a region of size S (a power of two), the mask is the inverse of S−1.
- R3: Words leave the output stream in the order they were accepted. Once `out_valid` is high with `out_ready` low, `out_valid` and `out_data` hold steady.
- R4: When BURST words are staged, they are written to memory in back-to-back cycles at consecutive pointer values. A write and a read are never issued in the same cycle.
- R5: Every memory address equals `base | (pointer & ~mask)`. The pointers wrap inside the region.
- R6: If the staging buffer holds fewer than BURST words for as many cycles as the timeout value, a partial burst is written. No partial write happens before that.
- R7: Readback select 0 returns the status word. Bit 31 always reads 1. Bit 30 is busy, meaning any word is held anywhere in the block. Bits 26:0 give the number of words stored in memory.
- R8: While read-hold is enabled, no read burst starts while the memory occupancy is below the threshold.
- R9: While clear is held, the block does the following: input is refused, any burst in progress is abandoned, all held words are discarded, the pointers and counters return to zero, and busy drops.
- R10: Readback select 1 reads 0. Select 2 returns the number of memory word transfers (writes plus reads) since clear was released. Select 3 returns the number of cycles since clear was released. The select is configuration offset 3, bits 2:0.
- R11: A write burst never starts unless the region has room for all staged words. Memory occupancy never exceeds the region size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration offset (0 control, 1 base, 2 mask, 3 readback select) |
| cfg_wdata | input | 32 | Configuration write data |
| rb_data | output | 32 | Readback word chosen by the select |
| in_valid | input | 1 | Input word valid |
| in_data | input | DW | Input word |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| out_valid | output | 1 | Output word valid |
| out_data | output | DW | Output word |
| out_ready | input | 1 | Consumer takes the output word |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | 30 | Memory write word address |
| mem_wdata | output | DW | Memory write data |
| mem_re | output | 1 | Memory read strobe |
| mem_raddr | output | 30 | Memory read word address |
| mem_rdata | input | DW | Memory read data, valid one cycle after the strobe |

## Verification
The main collision is a clear request that lands while a write burst is running. Clear must win: the burst stops after the word already on the bus, and the staged words never reach memory. To provoke it, the bench fills the staging buffer to exactly BURST words and writes the clear bit in the very next cycle. The result is judged at the ports. Fewer than BURST memory writes must have occurred, and the status must read not busy with zero occupancy. The transfer count must be zero. After release, only the words sent afterwards may come out, in order.

// File: rtl/membuf_ctrl.sv
module membuf_ctrl #(
  parameter int DW    = 64,
  parameter int BURST = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   rb_data,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  output logic          mem_we,
  output logic [29:0]   mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_re,
  output logic [29:0]   mem_raddr,
  input  logic [DW-1:0] mem_rdata
);
  localparam int AW = 30;
  localparam int IW = $clog2(BURST);
  localparam int CW = $clog2(BURST + 1);

  typedef enum logic [1:0] {IDLE, WR, RD} st_t;

  st_t            state;
  logic           clr, sup_en, rd_pend, busy, do_wr, do_rd, ob_free;
  logic [11:0]    tmo, age;
  logic [15:0]    thr;
  logic [2:0]     rb_sel;
  logic [AW-1:0]  base, mask, wr_ptr, rd_ptr, occ;
  logic [AW:0]    sz, room;
  logic [CW-1:0]  stg_cnt, bidx, blen, fidx, oidx, rd_len;
  logic [31:0]    xfer_cnt, cyc_cnt;
  logic [DW-1:0]  stg [BURST];
  logic [DW-1:0]  ob  [BURST];

  assign occ     = wr_ptr - rd_ptr;
  assign sz      = {1'b0, ~mask} + (AW+1)'(1);
  assign room    = sz - {1'b0, occ};
  assign ob_free = (fidx == '0) && !rd_pend && (state != RD);
  assign rd_len  = (occ < AW'(BURST)) ? occ[CW-1:0] : CW'(BURST);

  assign do_wr = (state == IDLE) && !clr && (stg_cnt != '0) &&
                 ((stg_cnt == CW'(BURST)) || (age >= tmo)) &&
                 (room >= (AW+1)'(stg_cnt));
  assign do_rd = (state == IDLE) && !clr && !do_wr && ob_free && (occ != '0) &&
                 !(sup_en && (occ < AW'(thr)));

  assign in_ready  = !clr && (state == IDLE) && (stg_cnt != CW'(BURST)) && !do_wr;
  assign out_valid = (oidx != fidx);
  assign out_data  = ob[oidx[IW-1:0]];

  assign mem_we    = (state == WR);
  assign mem_waddr = base | (wr_ptr & ~mask);
  assign mem_wdata = stg[bidx[IW-1:0]];
  assign mem_re    = (state == RD);
  assign mem_raddr = base | (rd_ptr & ~mask);

  assign busy = (occ != '0) || (stg_cnt != '0) || (fidx != '0) || rd_pend || (state != IDLE);

  always_comb begin
    case (rb_sel)
      3'd0:    rb_data = {1'b1, busy, 3'b000, occ[26:0]};
      3'd2:    rb_data = xfer_cnt;
      3'd3:    rb_data = cyc_cnt;
      default: rb_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clr    <= 1'b1;
      sup_en <= 1'b0;
      tmo    <= 12'd256;
      thr    <= '0;
      base   <= '0;
      mask   <= 30'h3F00_0000;
      rb_sel <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: begin
          clr    <= cfg_wdata[0];
          sup_en <= cfg_wdata[1];
          tmo    <= cfg_wdata[15:4];
          thr    <= cfg_wdata[31:16];
        end
        2'd1:    base   <= cfg_wdata[29:0];
        2'd2:    mask   <= cfg_wdata[29:0];
        default: rb_sel <= cfg_wdata[2:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state    <= IDLE;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      stg_cnt  <= '0;
      bidx     <= '0;
      blen     <= '0;
      fidx     <= '0;
      oidx     <= '0;
      rd_pend  <= 1'b0;
      age      <= '0;
      xfer_cnt <= '0;
      cyc_cnt  <= '0;
    end else begin
      cyc_cnt <= cyc_cnt + 32'd1;
      rd_pend <= mem_re;
      if (mem_we || mem_re) xfer_cnt <= xfer_cnt + 32'd1;

      if (state != IDLE || stg_cnt == '0) age <= '0;
      else if (age != 12'hFFF)            age <= age + 12'd1;

      if (in_valid && in_ready) begin
        stg[stg_cnt[IW-1:0]] <= in_data;
        stg_cnt <= stg_cnt + CW'(1);
      end

      case (state)
        IDLE: begin
          if (do_wr) begin
            state <= WR;
            bidx  <= '0;
          end else if (do_rd) begin
            state <= RD;
            bidx  <= '0;
            blen  <= rd_len;
          end
        end
        WR: begin
          wr_ptr <= wr_ptr + AW'(1);
          bidx   <= bidx + CW'(1);
          if (bidx == stg_cnt - CW'(1)) begin
            state   <= IDLE;
            stg_cnt <= '0;
          end
        end
        RD: begin
          rd_ptr <= rd_ptr + AW'(1);
          bidx   <= bidx + CW'(1);
          if (bidx == blen - CW'(1)) state <= IDLE;
        end
        default: state <= IDLE;
      endcase

      if (rd_pend) begin
        ob[fidx[IW-1:0]] <= mem_rdata;
        fidx <= fidx + CW'(1);
      end
      if (out_valid && out_ready) oidx <= oidx + CW'(1);
      if (fidx != '0 && oidx == fidx && !rd_pend && state != RD) begin
        fidx <= '0;
        oidx <= '0;
      end
    end
  end
endmodule

// File: rtl/membuf_ctrl_chk.sv
module membuf_ctrl_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          clr,
  input logic          sup_en,
  input logic [15:0]   thr,
  input logic [29:0]   base,
  input logic [29:0]   mask,
  input logic [29:0]   occ,
  input logic [30:0]   sz,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          mem_we,
  input logic [29:0]   mem_waddr,
  input logic          mem_re,
  input logic [29:0]   mem_raddr
);
  p_waddr_in_region_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ((mem_waddr & mask) == (base & mask)));

  p_raddr_in_region_r5: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> ((mem_raddr & mask) == (base & mask)));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, occ} <= sz));

  p_wr_rd_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  p_clear_blocks_input_r9: assert property (@(posedge clk) disable iff (rst)
    clr |-> !in_ready);

  p_clear_stops_memory_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && $past(clr)) |-> (!mem_we && !mem_re));

  p_read_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_re && !$past(mem_re)) |-> !($past(sup_en) && ($past(occ) < {14'd0, $past(thr)})));

  p_out_stable_r3: assert property (@(posedge clk) disable iff (rst || clr)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind membuf_ctrl membuf_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .sup_en(sup_en), .thr(thr),
  .base(base), .mask(mask), .occ(occ), .sz(sz),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .mem_we(mem_we), .mem_waddr(mem_waddr),
  .mem_re(mem_re), .mem_raddr(mem_raddr)
);

// File: tb/membuf_ctrl_test.sv
module membuf_ctrl_test;
  localparam logic [63:0] PAT = 64'hC0DE_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] rb_data;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_ready = 1'b0;
  logic        mem_we, mem_re;
  logic [29:0] mem_waddr, mem_raddr;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;

  logic [63:0] mem [1024];
  int checks = 0, errors = 0;
  int wr_count = 0, bad_addr = 0, ord_err = 0;
  logic [63:0] in_seq = '0, out_seq = '0;

  always #5 clk = ~clk;

  membuf_ctrl uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rb_data(rb_data), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        mem[mem_waddr[9:0]] <= mem_wdata;
        wr_count = wr_count + 1;
        if ((mem_waddr & 30'h3FFF_FFF0) != 30'h100) bad_addr = bad_addr + 1;
      end
      if (mem_re) begin
        mem_rdata <= mem[mem_raddr[9:0]];
        if ((mem_raddr & 30'h3FFF_FFF0) != 30'h100) bad_addr = bad_addr + 1;
      end
      if (out_valid && out_ready) begin
        if (out_data != (PAT | out_seq)) ord_err = ord_err + 1;
        out_seq = out_seq + 64'd1;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] ctrl(input int thr_v, input bit sup, input int tmo_v, input bit c);
    return (32'(thr_v) << 16) | (32'(tmo_v) << 4) | (32'(sup) << 1) | 32'(c);
  endfunction

  task automatic rb_expect(input logic [2:0] sel, input logic [31:0] exp, input string req);
    cfg_write(2'd3, {29'd0, sel});
    chk(req, rb_data, exp);
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = PAT | in_seq;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_seq = in_seq + 64'd1;
    end
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 status after reset", rb_data, 32'h8000_0000);
    chk("R1 in_ready held low", in_ready, 1'b0);
    chk("R1 out_valid low", out_valid, 1'b0);
  endtask

  task automatic t_setup;
    cfg_write(2'd1, 32'h100);
    cfg_write(2'd2, 32'h3FFF_FFF0);
    cfg_write(2'd0, ctrl(0, 0, 20, 0));
    wait_cyc(2);
    chk("R2 clear released, input open", in_ready, 1'b1);
  endtask

  task automatic t_full_burst;
    int w0;
    logic [63:0] s0;
    w0 = wr_count; s0 = in_seq;
    out_ready = 1'b0;
    push(8);
    wait_cyc(25);
    chk("R4 full burst word count", 64'(wr_count - w0), 64'd8);
    chk("R4 first word at region start", mem[10'h100], PAT | s0);
    chk("R4 last word consecutive", mem[10'h107], PAT | (s0 + 64'd7));
    rb_expect(3'd0, 32'hC000_0000, "R7 busy with words in output buffer");
    out_ready = 1'b1;
    wait_cyc(15);
    chk("R3 all words out", out_seq, in_seq);
    chk("R3 order kept", 64'(ord_err), 64'd0);
    rb_expect(3'd0, 32'h8000_0000, "R7 idle after drain");
  endtask

  task automatic t_timeout;
    int w0;
    w0 = wr_count;
    push(3);
    wait_cyc(10);
    chk("R6 no partial write before timeout", 64'(wr_count - w0), 64'd0);
    wait_cyc(30);
    chk("R6 partial burst after timeout", 64'(wr_count - w0), 64'd3);
    chk("R6 partial words delivered", out_seq, in_seq);
  endtask

  task automatic t_wrap;
    logic [63:0] s0;
    s0 = in_seq;
    out_ready = 1'b0;
    push(16);
    wait_cyc(30);
    chk("R5 pointer wrapped to region start", mem[10'h100], PAT | (s0 + 64'd5));
    rb_expect(3'd0, 32'hC000_0008, "R7 occupancy in memory");
    out_ready = 1'b1;
    wait_cyc(40);
    chk("R5 wrapped words in order", out_seq, in_seq);
    chk("R5 no address outside region", 64'(bad_addr), 64'd0);
    out_ready = 1'b0;
    push(32);
    wait_cyc(20);
    chk("R11 input refused when region full", in_ready, 1'b0);
    rb_expect(3'd0, 32'hC000_0010, "R11 occupancy capped at region size");
    out_ready = 1'b1;
    wait_cyc(80);
    chk("R11 all words out after full", out_seq, in_seq);
    chk("R3 order kept through full region", 64'(ord_err), 64'd0);
  endtask

  task automatic t_hold;
    logic [63:0] o0;
    cfg_write(2'd0, ctrl(5, 1, 4, 0));
    o0 = out_seq;
    push(3);
    wait_cyc(30);
    chk("R8 no read below threshold", out_seq, o0);
    rb_expect(3'd0, 32'hC000_0003, "R8 words kept in memory");
    push(3);
    wait_cyc(40);
    chk("R8 read once threshold met", out_seq, o0 + 64'd6);
    rb_expect(3'd0, 32'h8000_0000, "R8 drained");
    cfg_write(2'd0, ctrl(0, 0, 20, 0));
  endtask

  task automatic t_readback;
    logic [31:0] a;
    rb_expect(3'd1, 32'd0, "R10 select 1 reads zero");
    rb_expect(3'd2, 32'd130, "R10 transfer count");
    cfg_write(2'd3, 32'd3);
    a = rb_data;
    wait_cyc(10);
    chk("R10 cycle count advances", 64'(rb_data - a), 64'd10);
  endtask

  task automatic t_clear_collision;
    int w0;
    out_ready = 1'b0;
    w0 = wr_count;
    push(8);
    cfg_write(2'd0, ctrl(0, 0, 20, 1));
    wait_cyc(3);
    checks++;
    if (wr_count - w0 >= 8) begin
      errors++;
      $display("FAIL R9 burst not abandoned actual=%0d expected<8", wr_count - w0);
    end
    rb_expect(3'd0, 32'h8000_0000, "R9 empty while clear held");
    chk("R9 input refused in clear", in_ready, 1'b0);
    chk("R9 output empty in clear", out_valid, 1'b0);
    rb_expect(3'd2, 32'd0, "R9 transfer count reset");
    out_seq = in_seq;
    cfg_write(2'd0, ctrl(0, 0, 20, 0));
    out_ready = 1'b1;
    push(2);
    wait_cyc(40);
    chk("R9 only new words after clear", out_seq, in_seq);
    chk("R9 no stale words", 64'(ord_err), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_setup;
    t_full_burst;
    t_timeout;
    t_wrap;
    t_hold;
    t_readback;
    t_clear_collision;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule